// File: doc/BRIEF.md
# Overcurrent and Switch-Off Alert Logic

This block watches a stream of current-channel ADC samples and a few hot-swap control signals, and drives a sticky alert. Each accepted sample's upper eight bits are compared against an 8-bit limit. Depending on the enables, an ADC alert is raised either on a single sample above the limit or only after a run of consecutive samples above it. Hot-swap fault pulses and switch-off transitions raise their own status bits. The switch is switched off either by the ON pin going low or by the software-off bit going high.

Samples arrive on a valid/ready interface. The block never applies back-pressure. `samp_ready_o` is low while reset is asserted. From the first clock edge after reset it is high every cycle. A sample is taken on each cycle where `samp_valid_i` and `samp_ready_o` are both high. Cycles with `samp_valid_i` low carry no sample and leave the run count as it is.

Every status bit stays set until a clear request. A clear request lasts one cycle and releases itself. If a qualifying event arrives in the same cycle as the clear, the event wins, so a source that is still active sets its bit again at once.

Top module: `curr_alert_core`

## Requirements
- R1: After reset, the three status outputs are 0, `alert_o` is 0 and `samp_ready_o` is 0. From the first clock edge after reset, `samp_ready_o` is 1 every cycle.
- R2: When `alert_en_i[0]` is set, an accepted sample whose upper eight bits are strictly greater than `thresh_i` sets `stat_adc_o` at the next clock edge. A sample whose upper eight bits equal `thresh_i` does not set it, whatever its lower bits are. With `thresh_i` = 0xFF, no sample sets it.
- R3: When `alert_en_i[1]` is set, `stat_adc_o` is set only when four consecutive accepted samples exceed the limit. The fourth sample and each later exceeding sample in the run set it. An accepted sample that does not exceed the limit resets the run count to zero.
- R4: A cycle with `samp_valid_i` low carries no sample. It neither extends nor breaks the run count, and it sets no status bit.
- R5: When `alert_en_i[2]` is set, a high `hs_fault_i` sets `stat_fault_o` at the next clock edge.
- R6: When `alert_en_i[3]` is set, a transition of the effective on level (`on_pin_i` AND NOT `sw_off_i`) from 1 to 0 sets `stat_off_o` at the next clock edge. A level that stays at 0 sets nothing.
- R7: Raising `sw_off_i` while `on_pin_i` is high counts as a switch-off, exactly as a falling `on_pin_i` does.
- R8: A one-cycle `clear_i` resets all three status bits at the next clock edge. A qualifying event in the same cycle sets its bit again.
- R9: `alert_o` is 1 exactly when at least one of the three status bits is 1.
- R10: An event whose enable bit is 0 sets no status bit. The enable bits are `alert_en_i[0]` for a single sample, `[1]` for a run, `[2]` for a fault and `[3]` for a switch-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid_i | input | 1 | A current sample is offered |
| samp_ready_o | output | 1 | Sample accepted (always 1 after reset) |
| samp_data_i | input | SAMPLE_W (12) | Current-channel ADC result |
| thresh_i | input | 8 | Overcurrent limit, compared with the upper eight sample bits |
| alert_en_i | input | 4 | Enables: [0] single, [1] run, [2] fault, [3] switch-off |
| clear_i | input | 1 | One-cycle request to clear the status bits |
| hs_fault_i | input | 1 | Pulse: the switch latched off or entered cool-down after overcurrent |
| on_pin_i | input | 1 | ON pin level |
| sw_off_i | input | 1 | Software-off bit |
| stat_adc_o | output | 1 | Sticky ADC overcurrent status |
| stat_fault_o | output | 1 | Sticky hot-swap fault status |
| stat_off_o | output | 1 | Sticky switch-off status |
| alert_o | output | 1 | OR of the status bits |

## Verification
Suppose the run counter holds a wrong value. Then in run mode `stat_adc_o` rises one sample too early or too late. That shows one clock edge after the fourth exceeding sample, or after the sample before it. A stale previous-level register for the on/off edge detector shows up as a missing or spurious `stat_off_o` at the edge after the pin change. A sticky bit that leaks or fails to clear is visible on `alert_o` by the next edge. The tests therefore check the outputs cycle by cycle around each boundary: the fourth sample, the cycle after a gap, and a clear arriving together with an event.

// File: rtl/curr_alert_pkg.sv
package curr_alert_pkg;
  localparam int EN_SINGLE = 0;
  localparam int EN_RUN    = 1;
  localparam int EN_FAULT  = 2;
  localparam int EN_OFF    = 3;
  localparam int EN_W      = 4;

  localparam int ST_ADC   = 0;
  localparam int ST_FAULT = 1;
  localparam int ST_OFF   = 2;
  localparam int ST_W     = 3;
endpackage

// File: rtl/ovc_detect.sv
module ovc_detect #(
  parameter int SAMPLE_W = 12,
  parameter int THR_W    = 8,
  parameter int RUN_LEN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic [THR_W-1:0]    thr_i,
  output logic                single_hit_o,
  output logic                run_hit_o
);
  localparam int LOW_W = SAMPLE_W - THR_W;
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(RUN_LEN - 1);

  logic [SAMPLE_W-1:0] limit_full;
  logic                exceed;
  logic [CNT_W-1:0]    cnt_q;

  // Upper bits strictly above the limit <=> sample above {limit, all ones}
  generate
    if (LOW_W > 0) begin : g_low
      assign limit_full = {thr_i, {LOW_W{1'b1}}};
    end else begin : g_nolow
      assign limit_full = thr_i;
    end
  endgenerate

  assign exceed       = data_i > limit_full;
  assign single_hit_o = acc_i & exceed;
  assign run_hit_o    = acc_i & exceed & (cnt_q >= CNT_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (acc_i) begin
      if (!exceed)               cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  a_r3_run_implies_single: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit_o |-> single_hit_o);
  a_r3_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !single_hit_o) |=> cnt_q == '0);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> $stable(cnt_q));
endmodule

// File: rtl/off_edge_det.sv
module off_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic on_pin_i,
  input  logic sw_off_i,
  output logic off_evt_o
);
  logic eff_on;
  logic eff_q;

  assign eff_on    = on_pin_i & ~sw_off_i;
  assign off_evt_o = eff_q & ~eff_on;

  always_ff @(posedge clk) begin
    if (!rst_n) eff_q <= 1'b0;
    else        eff_q <= eff_on;
  end

  a_r6_no_double: assert property (@(posedge clk) disable iff (!rst_n)
    off_evt_o |=> !off_evt_o);
endmodule

// File: rtl/alert_status.sv
module alert_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clear_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (clear_i ? '0 : stat_q) | evt_i;
  end

  assign stat_o = stat_q;

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && evt_i == '0) |=> stat_q == '0);
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> (stat_q & $past(evt_i)) == $past(evt_i));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (stat_q & $past(stat_q)) == $past(stat_q));
endmodule

// File: rtl/curr_alert_core.sv
module curr_alert_core
  import curr_alert_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int THR_W    = 8,
  parameter int RUN_LEN  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_valid_i,
  output logic                samp_ready_o,
  input  logic [SAMPLE_W-1:0] samp_data_i,
  input  logic [THR_W-1:0]    thresh_i,
  input  logic [EN_W-1:0]     alert_en_i,
  input  logic                clear_i,
  input  logic                hs_fault_i,
  input  logic                on_pin_i,
  input  logic                sw_off_i,
  output logic                stat_adc_o,
  output logic                stat_fault_o,
  output logic                stat_off_o,
  output logic                alert_o
);
  logic            ready_q;
  logic            acc;
  logic            single_hit, run_hit, off_evt;
  logic [ST_W-1:0] evt, stat;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign samp_ready_o = ready_q;
  assign acc          = samp_valid_i & ready_q;

  ovc_detect #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .RUN_LEN(RUN_LEN)) u_ovc (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .data_i(samp_data_i),
    .thr_i(thresh_i), .single_hit_o(single_hit), .run_hit_o(run_hit)
  );

  off_edge_det u_off (
    .clk(clk), .rst_n(rst_n), .on_pin_i(on_pin_i), .sw_off_i(sw_off_i),
    .off_evt_o(off_evt)
  );

  always_comb begin
    evt           = '0;
    evt[ST_ADC]   = (alert_en_i[EN_SINGLE] & single_hit) |
                    (alert_en_i[EN_RUN] & run_hit);
    evt[ST_FAULT] = alert_en_i[EN_FAULT] & hs_fault_i;
    evt[ST_OFF]   = alert_en_i[EN_OFF] & off_evt;
  end

  alert_status #(.N(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clear_i(clear_i), .stat_o(stat)
  );

  assign stat_adc_o   = stat[ST_ADC];
  assign stat_fault_o = stat[ST_FAULT];
  assign stat_off_o   = stat[ST_OFF];
  assign alert_o      = |stat;

  logic eff_chk;
  assign eff_chk = on_pin_i & ~sw_off_i;

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> samp_ready_o);
  a_r6_off_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(eff_chk) && alert_en_i[EN_OFF]) |=> stat_off_o);
  a_r10_fault_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_fault_o && !alert_en_i[EN_FAULT]) |=> !stat_fault_o);
  a_r5_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fault_i && alert_en_i[EN_FAULT]) |=> stat_fault_o);
endmodule

// File: tb/test_curr_alert_core.sv
`timescale 1ns/1ps
module test_curr_alert_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid_i = 1'b0;
  logic        samp_ready_o;
  logic [11:0] samp_data_i = '0;
  logic [7:0]  thresh_i = 8'hFF;
  logic [3:0]  alert_en_i = 4'b0100;
  logic        clear_i = 1'b0;
  logic        hs_fault_i = 1'b0;
  logic        on_pin_i = 1'b0;
  logic        sw_off_i = 1'b0;
  logic        stat_adc_o, stat_fault_o, stat_off_o, alert_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  curr_alert_core i_curr_alert_core (
    .clk(clk), .rst_n(rst_n), .samp_valid_i(samp_valid_i), .samp_ready_o(samp_ready_o),
    .samp_data_i(samp_data_i), .thresh_i(thresh_i), .alert_en_i(alert_en_i),
    .clear_i(clear_i), .hs_fault_i(hs_fault_i), .on_pin_i(on_pin_i), .sw_off_i(sw_off_i),
    .stat_adc_o(stat_adc_o), .stat_fault_o(stat_fault_o), .stat_off_o(stat_off_o),
    .alert_o(alert_o)
  );

  // Packed view {alert, off, fault, adc}
  function automatic logic [3:0] obs();
    return {alert_o, stat_off_o, stat_fault_o, stat_adc_o};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    n_tests++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s: {alert,off,fault,adc} got %b expected %b", req, obs(), exp);
    end
  endtask

  // One clock step: drive at negedge, sample 1 ns after posedge, drop pulses
  task automatic step(input logic v, input logic [11:0] d, input logic flt, input logic clr);
    @(negedge clk);
    samp_valid_i = v; samp_data_i = d; hs_fault_i = flt; clear_i = clr;
    @(posedge clk); #1;
    samp_valid_i = 1'b0; hs_fault_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic idle(); step(1'b0, 12'h000, 1'b0, 1'b0); endtask
  task automatic do_clear(); step(1'b0, 12'h000, 1'b0, 1'b1); endtask
  task automatic smp(input logic [11:0] d); step(1'b1, d, 1'b0, 1'b0); endtask

  task automatic t_reset();
    chk("R1 reset status", 4'b0000);
    n_tests++;
    if (samp_ready_o !== 1'b0) begin
      n_fail++; $display("FAIL R1 ready in reset got %b expected 0", samp_ready_o);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    n_tests++;
    if (samp_ready_o !== 1'b1) begin
      n_fail++; $display("FAIL R1 ready after reset got %b expected 1", samp_ready_o);
    end
    chk("R1 status after reset", 4'b0000);
  endtask

  task automatic t_single();
    alert_en_i = 4'b0001; thresh_i = 8'h80;
    smp(12'h80F);   chk("R2 equal upper bits no set", 4'b0000);
    smp(12'h810);   chk("R2 exceed sets adc, R9 alert", 4'b1001);
    do_clear();     chk("R8 clear", 4'b0000);
    thresh_i = 8'hFF;
    smp(12'hFFF);   chk("R2 full-scale limit never exceeded", 4'b0000);
  endtask

  task automatic t_run();
    alert_en_i = 4'b0010; thresh_i = 8'h40;
    for (int i = 0; i < 3; i++) begin
      smp(12'h7A0); chk("R3 fewer than four no set", 4'b0000);
    end
    smp(12'h400);   chk("R3 miss resets run", 4'b0000);
    for (int i = 0; i < 3; i++) begin
      smp(12'h500); chk("R3 restart count", 4'b0000);
    end
    smp(12'h500);   chk("R3 fourth exceed sets adc", 4'b1001);
    step(1'b1, 12'h500, 1'b0, 1'b1); chk("R8 clear with active run sets again", 4'b1001);
    smp(12'h010);   do_clear(); chk("R8 clear after miss", 4'b0000);
    for (int i = 0; i < 3; i++) smp(12'h600);
    step(1'b0, 12'hFFF, 1'b0, 1'b0); chk("R4 invalid cycle no set", 4'b0000);
    step(1'b0, 12'h000, 1'b0, 1'b0); chk("R4 invalid low sample no break", 4'b0000);
    smp(12'h600);   chk("R4 gap keeps run count", 4'b1001);
    smp(12'h000);   do_clear();
    alert_en_i = 4'b0000;
    for (int i = 0; i < 5; i++) smp(12'hFF0);
    chk("R10 adc disabled no set", 4'b0000);
  endtask

  task automatic t_fault();
    alert_en_i = 4'b0100;
    step(1'b0, 12'h000, 1'b1, 1'b0); chk("R5 fault sets", 4'b1010);
    idle();                         chk("R9 fault sticky", 4'b1010);
    step(1'b0, 12'h000, 1'b1, 1'b1); chk("R8 clear with fault sets again", 4'b1010);
    do_clear();                     chk("R8 clear fault", 4'b0000);
    alert_en_i = 4'b0000;
    step(1'b0, 12'h000, 1'b1, 1'b0); chk("R10 fault disabled", 4'b0000);
  endtask

  task automatic t_off();
    alert_en_i = 4'b1000; sw_off_i = 1'b0;
    on_pin_i = 1'b1; idle();  chk("R6 on no set", 4'b0000);
    @(negedge clk); on_pin_i = 1'b0; @(posedge clk); #1;
    chk("R6 on pin fall sets off", 4'b1100);
    do_clear(); idle();       chk("R6 low level no re-set", 4'b0000);
    on_pin_i = 1'b1; idle();  chk("R6 turn on no set", 4'b0000);
    @(negedge clk); sw_off_i = 1'b1; @(posedge clk); #1;
    chk("R7 software off sets off", 4'b1100);
    do_clear();
    @(negedge clk); sw_off_i = 1'b0; @(posedge clk); #1;
    chk("R7 software release no set", 4'b0000);
    alert_en_i = 4'b0000;
    @(negedge clk); on_pin_i = 1'b0; @(posedge clk); #1;
    chk("R10 off disabled", 4'b0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk); #1;
        t_reset();
        t_single();
        t_run();
        t_fault();
        t_off();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule